// File: doc/BRIEF.md
# Programmable-Bandwidth Digital PLL Core

This block is the loop core of an all-digital first-order phase-locked loop. A reference square wave and a comparison square wave, which comes back from a divide-by-N counter outside the block, enter a phase detector. Either an exclusive-OR detector or an edge-triggered set/reset detector can be used, chosen by a select pin. The detector output sets the direction of an up/down counter. The counter length is chosen at run time by a 4-bit bandwidth code. Each time the counter wraps, it emits a carry (counting up) or a borrow (counting down). These pulses add or remove edges in a divide-by-two pulse-stealing stage, and that stage drives the loop output toward the external divider.

Everything runs on one system clock. The fast counting clock is supplied as the enable strobe `k_en` and the faster output-stage clock as the enable strobe `id_en`. The bandwidth code sets the loop gain: a short counter gives a wide capture range and fast lock, and a long counter gives a narrow bandwidth and slow lock. The code may be changed while the loop runs.

Top module: `dpll_core`

## Requirements
- R1: A synchronous active-high `rst` clears the counter, the detector state, the pending edits and all registered outputs. On the clock edge with `rst` high, `id_out`, `carry` and `borrow` become 0.
- R2: With `pd_sel` = 0 the detector is exclusive-OR: `pd_out` equals `ref_in` XOR `cmp_in` with no register in the path.
- R3: With `pd_sel` = 1 the detector is edge-triggered. It sets on the clock edge after a rising `ref_in` edge and clears on the edge after a rising `cmp_in` edge. When both rise in the same cycle, or neither rises, it holds. Edges are found by comparing each input with its value one clock earlier.
- R4: A bandwidth code of 0 stops the counter: it holds its value and `carry` and `borrow` stay 0.
- R5: For a code c from 1 to 15 the counter has c+2 bits, a modulus of 2^(c+2). On a clock with `k_en` high and `pd_out` low it increments. If it is at 2^(c+2)-1 it goes to 0, and `carry` is high for the single cycle after that edge.
- R6: On a clock with `k_en` high and `pd_out` high the counter decrements. From 0 it goes to 2^(c+2)-1, and `borrow` is high for the single cycle after that edge.
- R7: With `k_en` low the counter holds, and `carry` and `borrow` are 0 in the next cycle.
- R8: After a code change, without reset, the next count step operates on the low c+2 bits of the present count, with the new modulus.
- R9: With no pending edit, `id_out` toggles on each clock edge where `id_en` is high and holds otherwise.
- R10: A `borrow` pulse becomes a pending deletion one cycle later. At the next clock with `id_en` high, the toggle is suppressed and the deletion is cleared.
- R11: A `carry` pulse becomes a pending insertion one cycle later. On the next clock with `id_en` low, `id_out` toggles and the insertion is cleared. If `id_en` is high, only the normal toggle occurs and the insertion stays pending.
- R12: When an insertion and a deletion are both pending, both are cleared on the next clock and the stage behaves as in R9 for that clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| k_en | input | 1 | Counting-clock strobe for the up/down counter |
| id_en | input | 1 | Output-stage clock strobe |
| ref_in | input | 1 | Reference input |
| cmp_in | input | 1 | Comparison input from the external divider |
| bw_code | input | 4 | Bandwidth code; 0 stops the counter, c sets c+2 bits |
| pd_sel | input | 1 | 0: exclusive-OR detector, 1: edge-triggered detector |
| pd_out | output | 1 | Detector output (counter direction, 1 = down) |
| carry | output | 1 | One-cycle pulse on an upward wrap |
| borrow | output | 1 | One-cycle pulse on a downward wrap |
| id_out | output | 1 | Loop output to the external divider |

## Verification
The output-stage assertions assume that `id_en` is never high on two consecutive clocks. Only then does a pending insertion find a free cycle to use. The stimulus generates `id_en` from a divider with a ratio of at least two. The reference and comparison inputs are taken as synchronous to `clk` and stable between edges, so the bench drives them only at the falling edge. The bench also drives `k_en` and `bw_code` at the falling edge, and it changes the code only between phases while the counter is still running.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
  localparam int CODE_W = 4;
  localparam int KW     = (1 << CODE_W) + 1;

  // Mask of the live counter bits for a bandwidth code: code+2 ones, or none for code 0.
  function automatic logic [31:0] k_mask(input int unsigned code, input int unsigned kw);
    logic [31:0] m;
    if (code == 0) m = '0;
    else m = 32'hFFFF_FFFF >> (32 - kw + (kw - 2 - code));
    return m;
  endfunction
endpackage

// File: rtl/dpll_phase_det.sv
module dpll_phase_det (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  input  logic cmp_in,
  input  logic sel,
  output logic pd_out
);
  logic ref_q, cmp_q, ec_q;
  logic rise_ref, rise_cmp;

  assign rise_ref = ref_in & ~ref_q;
  assign rise_cmp = cmp_in & ~cmp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= 1'b0;
      cmp_q <= 1'b0;
      ec_q  <= 1'b0;
    end else begin
      ref_q <= ref_in;
      cmp_q <= cmp_in;
      if (rise_ref && !rise_cmp)      ec_q <= 1'b1;
      else if (rise_cmp && !rise_ref) ec_q <= 1'b0;
    end
  end

  assign pd_out = sel ? ec_q : (ref_in ^ cmp_in);

  // R3: a lone reference edge sets the edge detector
  a_r3_ec_set: assert property (@(posedge clk) disable iff (rst)
    (rise_ref && !rise_cmp) |=> ec_q);
  // R3: a lone comparison edge clears it
  a_r3_ec_clr: assert property (@(posedge clk) disable iff (rst)
    (rise_cmp && !rise_ref) |=> !ec_q);
  // R3: without lone edges the state holds
  a_r3_ec_hold: assert property (@(posedge clk) disable iff (rst)
    (rise_ref == rise_cmp) |=> $stable(ec_q));
endmodule

// File: rtl/dpll_kcounter.sv
module dpll_kcounter #(
  parameter int CW = dpll_pkg::CODE_W,
  localparam int KW = (1 << CW) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          k_en,
  input  logic [CW-1:0] code,
  input  logic          dn,
  output logic          carry,
  output logic          borrow
);
  logic [KW-1:0] cnt, mask, cur;
  logic          run, at_top, at_bot;

  assign mask   = KW'(dpll_pkg::k_mask(code, KW));
  assign cur    = cnt & mask;
  assign run    = k_en && (code != '0);
  assign at_top = run && !dn && (cur == mask);
  assign at_bot = run && dn && (cur == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      carry  <= 1'b0;
      borrow <= 1'b0;
    end else begin
      carry  <= at_top;
      borrow <= at_bot;
      if (run) begin
        if (at_top)      cnt <= '0;
        else if (at_bot) cnt <= mask;
        else if (dn)     cnt <= cur - 1'b1;
        else             cnt <= cur + 1'b1;
      end
    end
  end

  // R4: a stopped counter holds and is silent
  a_r4_off_hold: assert property (@(posedge clk) disable iff (rst)
    (code == '0) |=> ($stable(cnt) && !carry && !borrow));
  // R7: no strobe, no motion
  a_r7_no_strobe: assert property (@(posedge clk) disable iff (rst)
    !k_en |=> ($stable(cnt) && !carry && !borrow));
  // R5 / R6: the two wrap pulses never coincide
  a_r5_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(carry && borrow));
  // R5: an upward wrap lands on zero
  a_r5_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    carry |-> (cnt == '0));
endmodule

// File: rtl/dpll_idstage.sv
module dpll_idstage (
  input  logic clk,
  input  logic rst,
  input  logic id_en,
  input  logic carry,
  input  logic borrow,
  output logic id_out
);
  logic c_pend, b_pend;
  logic tog, c_clr, b_clr;

  always_comb begin
    tog   = 1'b0;
    c_clr = 1'b0;
    b_clr = 1'b0;
    if (c_pend && b_pend) begin
      tog   = id_en;
      c_clr = 1'b1;
      b_clr = 1'b1;
    end else if (b_pend) begin
      b_clr = id_en;
    end else if (c_pend) begin
      tog   = 1'b1;
      c_clr = !id_en;
    end else begin
      tog   = id_en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c_pend <= 1'b0;
      b_pend <= 1'b0;
      id_out <= 1'b0;
    end else begin
      c_pend <= (c_pend && !c_clr) || carry;
      b_pend <= (b_pend && !b_clr) || borrow;
      id_out <= id_out ^ tog;
    end
  end

  // R9: plain toggling with nothing pending
  a_r9_plain: assert property (@(posedge clk) disable iff (rst)
    (!c_pend && !b_pend) |=> (id_out == ($past(id_out) ^ $past(id_en))));
  // R10: a pending deletion swallows the strobe
  a_r10_delete: assert property (@(posedge clk) disable iff (rst)
    (b_pend && !c_pend && id_en) |=> $stable(id_out));
  // R11: a pending insertion fires in a free cycle
  a_r11_insert: assert property (@(posedge clk) disable iff (rst)
    (c_pend && !b_pend && !id_en) |=> (id_out != $past(id_out)));
  // R12: opposite edits cancel
  a_r12_cancel: assert property (@(posedge clk) disable iff (rst)
    (c_pend && b_pend && !carry && !borrow) |=> (!c_pend && !b_pend));
endmodule

// File: rtl/dpll_core.sv
module dpll_core #(
  parameter int CW = dpll_pkg::CODE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          k_en,
  input  logic          id_en,
  input  logic          ref_in,
  input  logic          cmp_in,
  input  logic [CW-1:0] bw_code,
  input  logic          pd_sel,
  output logic          pd_out,
  output logic          carry,
  output logic          borrow,
  output logic          id_out
);
  dpll_phase_det u_pd (
    .clk(clk), .rst(rst), .ref_in(ref_in), .cmp_in(cmp_in),
    .sel(pd_sel), .pd_out(pd_out)
  );

  dpll_kcounter #(.CW(CW)) u_kc (
    .clk(clk), .rst(rst), .k_en(k_en), .code(bw_code), .dn(pd_out),
    .carry(carry), .borrow(borrow)
  );

  dpll_idstage u_id (
    .clk(clk), .rst(rst), .id_en(id_en), .carry(carry), .borrow(borrow),
    .id_out(id_out)
  );

  // R1: reset leaves the registered outputs low
  a_r1_reset: assert property (@(posedge clk)
    rst |=> (!carry && !borrow && !id_out));
endmodule

// File: tb/dpll_core_bench.sv
module dpll_core_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic k_en = 1'b0, id_en = 1'b0, ref_in = 1'b0, cmp_in = 1'b0, pd_sel = 1'b0;
  logic [3:0] bw_code = 4'd0;
  logic pd_out, carry, borrow, id_out;

  always #5 clk = ~clk;

  dpll_core u_dpll_core (
    .clk(clk), .rst(rst), .k_en(k_en), .id_en(id_en), .ref_in(ref_in),
    .cmp_in(cmp_in), .bw_code(bw_code), .pd_sel(pd_sel), .pd_out(pd_out),
    .carry(carry), .borrow(borrow), .id_out(id_out)
  );

  typedef struct { bit pd; bit c; bit b; bit o; string tag; } exp_t;
  exp_t sb[$];
  int nvec = 0, nerr = 0;
  bit done = 0;

  // reference model state
  bit m_pr, m_pc, m_ec, m_cq, m_bq, m_cp, m_bp, m_out;
  int m_cnt;

  task automatic drive(input bit r, input bit c, input int code, input bit sel,
                       input bit ken, input bit iden, input bit rs, input string tag);
    bit rr, rc, pd, cq, bq, t;
    int modv, v;
    exp_t e;
    @(negedge clk);
    ref_in = r; cmp_in = c; bw_code = code[3:0]; pd_sel = sel;
    k_en = ken; id_en = iden; rst = rs;
    if (rs) begin
      m_pr = 0; m_pc = 0; m_ec = 0; m_cq = 0; m_bq = 0;
      m_cp = 0; m_bp = 0; m_out = 0; m_cnt = 0;
    end else begin
      rr = r && !m_pr; rc = c && !m_pc;
      pd = sel ? m_ec : (r != c);
      cq = 0; bq = 0;
      if (ken && code != 0) begin
        modv = 1 << (code + 2);
        v = m_cnt % modv;
        if (pd) begin
          if (v == 0) begin m_cnt = modv - 1; bq = 1; end else m_cnt = v - 1;
        end else begin
          if (v == modv - 1) begin m_cnt = 0; cq = 1; end else m_cnt = v + 1;
        end
      end
      // output stage from the edits pending before this edge
      t = iden;
      if (m_cp && m_bp) begin m_cp = 0; m_bp = 0; end
      else if (m_bp) begin t = 0; if (iden) m_bp = 0; end
      else if (m_cp) begin t = 1; if (!iden) m_cp = 0; end
      m_out = m_out ^ t;
      m_cp = m_cp | m_cq; m_bp = m_bp | m_bq;
      m_cq = cq; m_bq = bq;
      if (rr && !rc) m_ec = 1; else if (rc && !rr) m_ec = 0;
      m_pr = r; m_pc = c;
    end
    e.pd = sel ? m_ec : (r != c);
    e.c = m_cq; e.b = m_bq; e.o = m_out; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic run_phase(input int n, input int rper, input int cper, input int coff,
                           input int code, input bit sel, input int kdiv, input int idiv,
                           input string tag);
    for (int i = 0; i < n; i++) begin
      drive((i % rper) < rper / 2, ((i + coff) % cper) < cper / 2, code, sel,
            (i % kdiv) == 0, (i % idiv) == 0, 1'b0, tag);
    end
  endtask

  // monitor: pops one expectation per edge and compares
  initial begin
    forever begin
      @(posedge clk); #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        nvec++;
        if (pd_out !== e.pd || carry !== e.c || borrow !== e.b || id_out !== e.o) begin
          nerr++;
          $display("FAIL %s: pd/carry/borrow/out = %b%b%b%b expected %b%b%b%b",
                   e.tag, pd_out, carry, borrow, id_out, e.pd, e.c, e.b, e.o);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) drive(0, 0, 0, 0, 0, 0, 1, "R1");
    run_phase(200, 8, 10, 0, 0, 0, 1, 2, "R4");
    run_phase(100, 8, 8, 0, 0, 0, 1, 2, "R9");
    run_phase(200, 8, 8, 0, 1, 0, 1, 3, "R5");
    run_phase(200, 8, 8, 4, 1, 0, 1, 3, "R6_R10");
    run_phase(200, 8, 8, 0, 1, 0, 1, 2, "R11");
    run_phase(300, 12, 12, 3, 3, 0, 3, 3, "R7");
    run_phase(200, 12, 12, 3, 2, 0, 1, 2, "R2");
    run_phase(400, 10, 11, 2, 2, 1, 1, 3, "R3");
    run_phase(300, 10, 9, 1, 2, 1, 1, 3, "R3");
    run_phase(150, 16, 16, 0, 4, 0, 1, 3, "R8");
    run_phase(150, 16, 16, 8, 1, 0, 1, 3, "R8");
    run_phase(150, 16, 16, 0, 15, 0, 1, 3, "R8");
    run_phase(150, 16, 16, 8, 2, 0, 1, 3, "R8");
    run_phase(600, 16, 15, 0, 1, 0, 1, 5, "R12");
    run_phase(400, 6, 7, 1, 1, 1, 1, 4, "R12");
    for (int i = 0; i < 2; i++) drive(1, 0, 1, 0, 1, 1, 1, "R1");
    run_phase(100, 8, 8, 0, 1, 0, 1, 3, "R1");
    for (int i = 0; i < 4; i++) drive(0, 0, 0, 0, 0, 0, 0, "R7");
    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule